// File: doc/BRIEF.md
# Eight-Channel Multi-Mode LO Phase Generator

This block produces one square-wave local-oscillator output for each of eight channels. Each output runs at a divided-down rate of a fast reference. A two-bit mode input decides where the reference comes from and how the phase is chosen. In the eight-phase mode, one shared reference at eight times the output rate is divided by eight, and every channel can place its wave at any of eight 45-degree steps. In the four-phase mode, each channel has its own reference at four times the output rate, divided by four, with four 90-degree steps. In the external mode, each channel simply divides its own reference by four and ignores all programming. The fourth encoding turns every output off.

All logic runs on one system clock. The references arrive as single-cycle tick enables in that clock domain. The shared reference is `ref8_tick`, and the per-channel references are the bits of `ref4_tick`. Configuration is shifted in serially as five bits per channel: three phase bits and a channel-off bit. The shifted bits go live only on a load strobe. A phase change then waits for the divider of that channel to wrap. A synchronous restart input returns every divider to count zero on the same cycle, so that all channels are aligned.

Top module: `lo_phase_gen`

## Requirements
- R1: With `mode` = 2'b00, every bit of `lo_out` is low.
- R2: With `mode` = 2'b01 (eight-phase), let n be the number of `ref8_tick` pulses since the last divider restart, taken mod 8, and let p = {B1,B2,B3} with B3 as the LSB. Channel output is high exactly when (n - p) mod 8 < 4. B0 has no effect.
- R3: With `mode` = 2'b10 (four-phase), let n be the count of that channel's own `ref4_tick` bit, taken mod 4, and let p = {B2,B3} with B3 as the LSB. The output is high exactly when (n - p) mod 4 < 2. B0 and B1 have no effect, and each channel advances only on its own tick bit.
- R4: With `mode` = 2'b11 (external), each channel output is high exactly when its own tick count mod 4 is below 2. All loaded configuration bits, including B4, are ignored.
- R5: B4 = 1 holds that channel's output low in modes 2'b01 and 2'b10. B4 = 0 lets the output run.
- R6: Configuration is shifted in one bit per clock while `ser_shift` is high, 40 bits in total: channel 0 first, and bit B0 first within each channel. Shifting has no effect on the outputs until `ser_load` is pulsed.
- R7: On `ser_load`, the off bit takes effect at once. In modes 2'b01 and 2'b10, a new phase code takes effect only when the channel's divider wraps from its last count to zero.
- R8: `sync_rst` restarts all dividers at count zero on the next edge, with priority over ticks, and applies pending phase codes at the same time.
- R9: While `rst_n` is low, all outputs are low at once. After reset, every channel is off at phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode | input | 2 | 00 off, 01 eight-phase, 10 four-phase, 11 external |
| ref8_tick | input | 1 | Shared eight-times reference tick |
| ref4_tick | input | 8 | Per-channel four-times reference ticks |
| sync_rst | input | 1 | Synchronous restart of all dividers |
| ser_data | input | 1 | Serial configuration bit |
| ser_shift | input | 1 | Shift enable for the serial register |
| ser_load | input | 1 | Copies the serial register into the live configuration |
| lo_out | output | 8 | Per-channel LO outputs |

## Verification
The hardest case to create from the ports is a phase change that is pending while the divider is mid-period. The divider state must be held at a known count while 41 cycles of shifting and loading go by. The bench does this by stopping the tick enables during the load. It then checks that the old wave continues up to the wrap and that the new phase appears only after it. Per-channel bit order is covered by giving each channel a different phase and one channel its off bit. Independent per-channel dividers are covered by ticking only half of the channels before a synchronous restart.

// File: rtl/lo_gen_pkg.sv
`timescale 1ns/1ps
package lo_gen_pkg;
  localparam int CFG_W = 5;   // bits per channel in the serial stream
  localparam int PH8_W = 3;   // shared divide-by-eight counter width
  localparam int PH4_W = 2;   // per-channel divide-by-four counter width

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_EIGHT = 2'b01,
    MODE_FOUR  = 2'b10,
    MODE_EXT   = 2'b11
  } lo_mode_e;

  // ph holds {B1,B2,B3}; ph[0] is B3 (LSB)
  typedef struct packed {
    logic             off;
    logic [PH8_W-1:0] ph;
  } chan_cfg_t;
endpackage

// File: rtl/lo_rst_sync.sv
`timescale 1ns/1ps
module lo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_sync_n = stg_q[1];
endmodule

// File: rtl/lo_cfg_shift.sv
`timescale 1ns/1ps
module lo_cfg_shift
  import lo_gen_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ser_data,
  input  logic                       ser_shift,
  input  logic                       ser_load,
  output chan_cfg_t [N_CH-1:0]       cfg_o
);
  localparam int SR_W = N_CH * CFG_W;

  logic [SR_W-1:0]       sr_q, sr_d;
  chan_cfg_t [N_CH-1:0]  stage_q, stage_d, decoded;

  // first bit shifted ends at the MSB: channel 0, B0
  always_comb begin
    sr_d = sr_q;
    if (ser_shift) sr_d = {sr_q[SR_W-2:0], ser_data};
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_dec
    localparam int BASE = SR_W - 1 - c * CFG_W;  // position of B0
    assign decoded[c].off = sr_q[BASE-4];
    assign decoded[c].ph  = {sr_q[BASE-1], sr_q[BASE-2], sr_q[BASE-3]};
  end

  always_comb begin
    stage_d = stage_q;
    if (ser_load) stage_d = decoded;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q    <= '0;
      stage_q <= {N_CH{chan_cfg_t'{off: 1'b1, ph: '0}}};
    end else begin
      sr_q    <= sr_d;
      stage_q <= stage_d;
    end
  end

  assign cfg_o = stage_q;

  // R6: configuration only changes on a load strobe
  a_r6_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_load |=> $stable(stage_q));
endmodule

// File: rtl/lo_chan.sv
`timescale 1ns/1ps
module lo_chan
  import lo_gen_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  lo_mode_e         mode,
  input  logic             tick4,
  input  logic             sync_rst,
  input  logic [PH8_W-1:0] cnt8,
  input  logic             wrap8,
  input  chan_cfg_t        cfg,
  output logic             lo
);
  localparam logic [PH4_W-1:0] LAST4 = {PH4_W{1'b1}};

  logic [PH4_W-1:0] cnt4_q, cnt4_d, diff4;
  logic [PH8_W-1:0] ph_q, ph_d, diff8;
  logic             wrap4, upd, lo_raw;

  assign wrap4 = tick4 && (cnt4_q == LAST4) && !sync_rst;

  always_comb begin
    cnt4_d = cnt4_q;
    if (sync_rst)   cnt4_d = '0;
    else if (tick4) cnt4_d = cnt4_q + 1'b1;
  end

  always_comb begin
    unique case (mode)
      MODE_EIGHT: upd = wrap8;
      MODE_FOUR:  upd = wrap4;
      default:    upd = 1'b1;
    endcase
    if (sync_rst) upd = 1'b1;
    ph_d = upd ? cfg.ph : ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt4_q <= '0;
      ph_q   <= '0;
    end else begin
      cnt4_q <= cnt4_d;
      ph_q   <= ph_d;
    end
  end

  assign diff8 = cnt8 - ph_q;
  assign diff4 = cnt4_q - ph_q[PH4_W-1:0];

  always_comb begin
    unique case (mode)
      MODE_EIGHT: lo_raw = !cfg.off && !diff8[PH8_W-1];
      MODE_FOUR:  lo_raw = !cfg.off && !diff4[PH4_W-1];
      MODE_EXT:   lo_raw = !cnt4_q[PH4_W-1];
      default:    lo_raw = 1'b0;
    endcase
  end

  assign lo = lo_raw && rst_n;

  // R8: restart clears the per-channel divider
  a_r8_div_restart: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rst |=> (cnt4_q == '0));
  // R7: in four-phase mode the phase only moves at a wrap
  a_r7_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FOUR && !sync_rst && cnt4_q != LAST4) |=> $stable(ph_q));
  // R5: off bit keeps the output low in programmed modes
  a_r5_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_EIGHT || mode == MODE_FOUR) && cfg.off) |-> !lo);
endmodule

// File: rtl/lo_phase_gen.sv
`timescale 1ns/1ps
module lo_phase_gen
  import lo_gen_pkg::*;
#(
  parameter int N_CH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode,
  input  logic            ref8_tick,
  input  logic [N_CH-1:0] ref4_tick,
  input  logic            sync_rst,
  input  logic            ser_data,
  input  logic            ser_shift,
  input  logic            ser_load,
  output logic [N_CH-1:0] lo_out
);
  localparam logic [PH8_W-1:0] LAST8 = {PH8_W{1'b1}};

  logic                 rst_int_n;
  lo_mode_e             mode_e;
  chan_cfg_t [N_CH-1:0] cfg;
  logic [PH8_W-1:0]     cnt8_q, cnt8_d;
  logic                 wrap8;

  assign mode_e = lo_mode_e'(mode);

  lo_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  lo_cfg_shift #(.N_CH(N_CH)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .ser_data  (ser_data),
    .ser_shift (ser_shift),
    .ser_load  (ser_load),
    .cfg_o     (cfg)
  );

  assign wrap8 = ref8_tick && (cnt8_q == LAST8) && !sync_rst;

  always_comb begin
    cnt8_d = cnt8_q;
    if (sync_rst)       cnt8_d = '0;
    else if (ref8_tick) cnt8_d = cnt8_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) cnt8_q <= '0;
    else            cnt8_q <= cnt8_d;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    lo_chan u_ch (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .mode     (mode_e),
      .tick4    (ref4_tick[c]),
      .sync_rst (sync_rst),
      .cnt8     (cnt8_q),
      .wrap8    (wrap8),
      .cfg      (cfg[c]),
      .lo       (lo_out[c])
    );
  end

  // R1: disabled mode drives nothing
  a_r1_off_mode: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_e == MODE_OFF) |-> (lo_out == '0));
  // R8: restart clears the shared divider
  a_r8_shared_restart: assert property (@(posedge clk) disable iff (!rst_int_n)
    sync_rst |=> (cnt8_q == '0));
endmodule

// File: tb/lo_phase_gen_bench.sv
`timescale 1ns/1ps
module lo_phase_gen_bench;
  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [1:0]     mode;
  logic           ref8_tick;
  logic [NCH-1:0] ref4_tick;
  logic           sync_rst, ser_data, ser_shift, ser_load;
  logic [NCH-1:0] lo_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [4:0] codes [NCH];

  always #2 clk = ~clk;   // 250 MHz

  lo_phase_gen #(.N_CH(NCH)) u_lo_phase_gen (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ref8_tick(ref8_tick),
    .ref4_tick(ref4_tick), .sync_rst(sync_rst), .ser_data(ser_data),
    .ser_shift(ser_shift), .ser_load(ser_load), .lo_out(lo_out)
  );

  // entry: {mode, code B4..B0, pattern bit n = output at count n}
  localparam logic [14:0] VEC [0:15] = '{
    {2'b01, 5'b00000, 8'h0F}, {2'b01, 5'b01000, 8'h1E},
    {2'b01, 5'b01100, 8'h78}, {2'b01, 5'b01011, 8'hE1},
    {2'b01, 5'b01110, 8'h87}, {2'b01, 5'b00011, 8'hF0},
    {2'b01, 5'b10000, 8'h00}, {2'b10, 5'b00000, 8'h03},
    {2'b10, 5'b01000, 8'h06}, {2'b10, 5'b00110, 8'h0C},
    {2'b10, 5'b01101, 8'h09}, {2'b10, 5'b11100, 8'h00},
    {2'b11, 5'b11100, 8'h03}, {2'b11, 5'b00110, 8'h03},
    {2'b00, 5'b01000, 8'h00}, {2'b00, 5'b00000, 8'h00}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // R6: channel 0 first, B0 first
  task automatic load_cfg(input bit watch, input logic [7:0] hold_v);
    for (int c = 0; c < NCH; c++)
      for (int b = 0; b < 5; b++) begin
        ser_data = codes[c][b]; ser_shift = 1'b1;
        step();
        if (watch) chk("R6 shift without load", lo_out, hold_v);
      end
    ser_shift = 1'b0; ser_data = 1'b0; ser_load = 1'b1;
    step();
    ser_load = 1'b0;
  endtask

  function automatic logic [4:0] enc8(input int p, input bit off);
    return {off, p[0], p[1], p[2], 1'b0};
  endfunction

  task automatic restart();
    sync_rst = 1'b1; ref8_tick = 1'b1; ref4_tick = '1;
    step();
    sync_rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 2'b01; ref8_tick = 1'b1; ref4_tick = '1;
    sync_rst = 1'b0; ser_data = 1'b0; ser_shift = 1'b0; ser_load = 1'b0;
    repeat (3) step();
    chk("R9 outputs low in reset", lo_out, 8'h00);
    rst_n = 1'b1;
    repeat (3) step();
    restart();
    for (int i = 0; i < 8; i++) begin
      if (i > 0) step();
      chk("R9 all off after reset", lo_out, 8'h00);
    end

    // vector table walk
    for (int e = 0; e < 16; e++) begin
      logic [1:0] m; logic [4:0] code; logic [7:0] pat; int per; string tag;
      m = VEC[e][14:13]; code = VEC[e][12:8]; pat = VEC[e][7:0];
      per = (m == 2'b01) ? 8 : 4;
      tag = (m == 2'b00) ? "R1" : (m == 2'b01) ? "R2" : (m == 2'b10) ? "R3" : "R4";
      ref8_tick = 1'b0; ref4_tick = '0; mode = m;
      for (int c = 0; c < NCH; c++) codes[c] = code;
      load_cfg(1'b0, 8'h00);
      restart();
      for (int i = 0; i < 2 * per; i++) begin
        if (i > 0) step();
        chk(tag, lo_out, pat[i % per] ? 8'hFF : 8'h00);
      end
    end

    // R2 R5 R6: distinct phase per channel, channel 7 off
    ref8_tick = 1'b0; ref4_tick = '0; mode = 2'b01;
    for (int c = 0; c < NCH; c++) codes[c] = enc8(c, c == 7);
    load_cfg(1'b0, 8'h00);
    restart();
    for (int i = 0; i < 8; i++) begin
      logic [7:0] ex;
      if (i > 0) step();
      for (int c = 0; c < NCH; c++) ex[c] = (c < 7) && (((i - c) & 7) < 4);
      chk("R2 R5 per-channel phase", lo_out, ex);
    end

    // R7: phase change waits for the divider wrap
    ref8_tick = 1'b0; ref4_tick = '0;
    for (int c = 0; c < NCH; c++) codes[c] = enc8(0, 1'b0);
    load_cfg(1'b0, 8'h00);
    restart();
    step(); step();                      // count now 2
    ref8_tick = 1'b0; ref4_tick = '0;
    for (int c = 0; c < NCH; c++) codes[c] = enc8(4, 1'b0);
    load_cfg(1'b1, 8'hFF);
    chk("R7 phase held after load", lo_out, 8'hFF);
    ref8_tick = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      int n; int p;
      step();
      n = (2 + k) % 8; p = (2 + k >= 8) ? 4 : 0;
      chk("R7 switch at wrap", lo_out, (((n - p) & 7) < 4) ? 8'hFF : 8'h00);
    end

    // R3: per-channel ticks in four-phase mode
    ref8_tick = 1'b0; ref4_tick = '0; mode = 2'b10;
    for (int c = 0; c < NCH; c++) codes[c] = 5'b01000;
    load_cfg(1'b0, 8'h00);
    restart();
    ref4_tick = 8'h0F;
    step();
    ref4_tick = '0;
    chk("R3 independent dividers", lo_out, 8'h0F);

    // R4 R8: external mode, divergent counts then restart
    mode = 2'b11;
    restart();
    ref4_tick = 8'h0F; ref8_tick = 1'b0;
    step(); step();
    ref4_tick = '0;
    chk("R4 external divide", lo_out, 8'hF0);
    sync_rst = 1'b1; ref4_tick = 8'hF0;
    step();
    sync_rst = 1'b0; ref4_tick = '0;
    chk("R8 restart aligns", lo_out, 8'hFF);
    ref4_tick = '1;
    step(); step();
    ref4_tick = '0;
    chk("R8 aligned after restart", lo_out, 8'h00);

    // R9: asynchronous reset mid-run
    restart();
    ref4_tick = '0; ref8_tick = 1'b0;
    chk("R4 before reset", lo_out, 8'hFF);
    #0.5 rst_n = 1'b0;
    #0.5 chk("R9 async clear", lo_out, 8'h00);
    step();
    rst_n = 1'b1;
    repeat (3) step();
    mode = 2'b10;
    restart();
    chk("R9 off after async reset", lo_out, 8'h00);

    summary();
    $finish;
  end
endmodule